// File: doc/BRIEF.md
# Programmable Parallel I/O Port Controller

This block connects a CPU's strobed peripheral bus to three 8-bit parallel ports, called A, B and C, and a control register. The CPU selects one of the three port registers or the control register with a 2-bit address. It moves data with an active-low chip select and separate active-low read and write strobes. The data bus is split into a write-data input, a read-data output and a read-data output enable. Each port has separate pin-input, pin-output and pin-output-enable vectors. The ports are arranged in two groups. The first group holds port A and the upper nibble of port C. The second group holds port B and the lower nibble of port C.

A control write with bit 7 set is a configuration word. It holds a direction for port A, port B and each nibble of port C, plus a mode code for each group. The mode codes are stored and read back, but every mode behaves as basic input/output. A configuration write clears every output latch. A control write with bit 7 clear sets or clears one bit of port C and leaves the configuration alone. Port A input data is captured when a read strobe starts. Port B and port C inputs are taken live from the pins.

The strobes are sampled on a clock by a three-state bus sequencer with the states BUS_IDLE, BUS_READ and BUS_WRITE. Every state goes to BUS_WRITE while a qualified write is present. Otherwise it goes to BUS_READ while a qualified read is present. Otherwise it returns to BUS_IDLE. A write is committed on the transition into BUS_WRITE from either of the other states. Port A is captured on the transition into BUS_READ from either of the other states.

Top module: `par_io_ctrl`

## Requirements
- R1: Address 0 selects port A, address 1 selects port B, address 2 selects port C and address 3 selects the control register, for both reads and writes.
- R2: A read is qualified when cs_n=0, rd_n=0 and wr_n=1. A write is qualified when cs_n=0, wr_n=0 and rd_n=1. A write takes effect once, in the first clock of its qualified strobe, using din and addr sampled there. A change of din while the strobe is held has no effect.
- R3: doe is 1 exactly while a read is qualified. It is 0 when cs_n=1, when both strobes are high, and when both strobes are low.
- R4: After reset the control register reads back 0x9B, which means all directions are input and all mode codes are zero. All pin output enables are 0, all output latches hold 0xFF, and the captured port A value is 0x00.
- R5: In a configuration word (bit 7 = 1), bits 6..5 are the first group's mode, bit 4 is the port A direction, bit 3 is the port C upper direction, bit 2 is the second group's mode, bit 1 is the port B direction and bit 0 is the port C lower direction. A direction bit of 1 means input, which gives output enable 0. A direction bit of 0 means output, which gives output enable 1 on every line of that byte or nibble.
- R6: A configuration write clears the port A, port B and port C output latches to 0x00 in the same clock in which it is committed.
- R7: A control register read returns bit 7 as 1 and bits 6..0 as the stored configuration.
- R8: A control write with bit 7 = 0 sets port C latch bit din[3:1] to din[0]. The other latch bits and the stored configuration are unchanged.
- R9: A read of port A while it is an input returns the pin value captured on the clock in which the qualified read started. Pin changes during the held strobe do not change it.
- R10: A read of port B while it is an input returns the live pins. A read of port C returns the live pins for each input nibble.
- R11: A read of a port or nibble that is configured as output returns its output latch. Port data writes update the latch whatever the direction.
- R12: Non-zero mode codes are stored and read back, and the ports behave exactly as in basic input/output mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 2 | Register select |
| din | input | 8 | CPU write data |
| dout | output | 8 | CPU read data |
| doe | output | 1 | Read data output enable |
| pa_in | input | 8 | Port A pin input |
| pa_out | output | 8 | Port A output latch |
| pa_oe | output | 8 | Port A pin output enable |
| pb_in | input | 8 | Port B pin input |
| pb_out | output | 8 | Port B output latch |
| pb_oe | output | 8 | Port B pin output enable |
| pc_in | input | 8 | Port C pin input |
| pc_out | output | 8 | Port C output latch |
| pc_oe | output | 8 | Port C pin output enable |

## Verification
The bench configures the ports in four ways: all inputs, all outputs, port C split with its upper nibble as input and its lower nibble as output, and non-zero mode codes. Comparing these shows that the direction bits are mapped to the right byte or nibble. It also shows that the mode codes have no side effects. Reads are run while the pins change during a held strobe, which tells the latched port A apart from the live ports B and C. Writes are tried with a deselected chip, with both strobes low, and with din changing during one long strobe, to show that only qualified strobe starts commit. Bit set/reset commands are issued between configuration writes to show that they touch one latch bit and never the configuration.

// File: rtl/par_io_pkg.sv
package par_io_pkg;

    localparam int PORT_W = 8;
    localparam int NIB_W  = PORT_W / 2;
    localparam int NIB_N  = PORT_W / NIB_W;
    localparam int SEL_W  = $clog2(PORT_W);
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] SEL_PA = 2'd0;
    localparam logic [ADDR_W-1:0] SEL_PB = 2'd1;
    localparam logic [ADDR_W-1:0] SEL_PC = 2'd2;
    localparam logic [ADDR_W-1:0] SEL_CW = 2'd3;

    typedef enum logic [1:0] {
        BUS_IDLE  = 2'd0,
        BUS_READ  = 2'd1,
        BUS_WRITE = 2'd2
    } bus_state_e;

    // bit order matters: it is the control word layout below bit 7
    typedef struct packed {
        logic [1:0] a_mode;
        logic       a_in;
        logic       cu_in;
        logic       b_mode;
        logic       b_in;
        logic       cl_in;
    } cfg_t;

    localparam cfg_t CFG_RESET = '{a_mode: 2'b00, a_in: 1'b1, cu_in: 1'b1,
                                   b_mode: 1'b0, b_in: 1'b1, cl_in: 1'b1};

endpackage

// File: rtl/par_io_bus_seq.sv
module par_io_bus_seq
    import par_io_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cs_n,
    input  logic rd_n,
    input  logic wr_n,
    output logic rd_qual,
    output logic wr_commit,
    output logic rd_start
);

    bus_state_e state_q;
    bus_state_e state_d;
    logic       wr_qual;

    assign rd_qual = !cs_n && !rd_n && wr_n;
    assign wr_qual = !cs_n && !wr_n && rd_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= BUS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE: begin
                if (wr_qual)      state_d = BUS_WRITE;
                else if (rd_qual) state_d = BUS_READ;
            end
            BUS_READ: begin
                if (wr_qual)       state_d = BUS_WRITE;
                else if (!rd_qual) state_d = BUS_IDLE;
            end
            BUS_WRITE: begin
                if (rd_qual)       state_d = BUS_READ;
                else if (!wr_qual) state_d = BUS_IDLE;
            end
            default: state_d = BUS_IDLE;
        endcase
    end

    always_comb begin
        wr_commit = wr_qual && (state_q != BUS_WRITE);
        rd_start  = rd_qual && (state_q != BUS_READ);
    end

endmodule

// File: rtl/par_io_cfg.sv
module par_io_cfg
    import par_io_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ctrl_wr,
    input  logic [PORT_W-1:0] din,
    output cfg_t              cfg_q,
    output logic              mode_set,
    output logic              bsr_set
);

    assign mode_set = ctrl_wr && din[PORT_W-1];
    assign bsr_set  = ctrl_wr && !din[PORT_W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= CFG_RESET;
        end else if (mode_set) begin
            cfg_q <= cfg_t'(din[PORT_W-2:0]);
        end
    end

endmodule

// File: rtl/par_io_latches.sv
module par_io_latches
    import par_io_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_commit,
    input  logic              rd_start,
    input  logic [ADDR_W-1:0] addr,
    input  logic [PORT_W-1:0] din,
    input  logic              mode_set,
    input  logic              bsr_set,
    input  logic [PORT_W-1:0] pa_in,
    output logic [PORT_W-1:0] lat_a,
    output logic [PORT_W-1:0] lat_b,
    output logic [PORT_W-1:0] lat_c,
    output logic [PORT_W-1:0] cap_a
);

    logic [SEL_W-1:0] bit_sel;
    assign bit_sel = din[SEL_W:1];

    always_ff @(posedge clk) begin
        if (rst) begin
            lat_a <= '1;
            lat_b <= '1;
        end else if (mode_set) begin
            lat_a <= '0;
            lat_b <= '0;
        end else if (wr_commit) begin
            if (addr == SEL_PA) lat_a <= din;
            if (addr == SEL_PB) lat_b <= din;
        end
    end

    for (genvar b = 0; b < PORT_W; b++) begin : g_pc_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                lat_c[b] <= 1'b1;
            end else if (mode_set) begin
                lat_c[b] <= 1'b0;
            end else if (bsr_set && (bit_sel == SEL_W'(b))) begin
                lat_c[b] <= din[0];
            end else if (wr_commit && (addr == SEL_PC)) begin
                lat_c[b] <= din[b];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_a <= '0;
        end else if (rd_start) begin
            cap_a <= pa_in;
        end
    end

endmodule

// File: rtl/par_io_ctrl.sv
module par_io_ctrl
    import par_io_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cs_n,
    input  logic        rd_n,
    input  logic        wr_n,
    input  logic [1:0]  addr,
    input  logic [7:0]  din,
    output logic [7:0]  dout,
    output logic        doe,
    input  logic [7:0]  pa_in,
    output logic [7:0]  pa_out,
    output logic [7:0]  pa_oe,
    input  logic [7:0]  pb_in,
    output logic [7:0]  pb_out,
    output logic [7:0]  pb_oe,
    input  logic [7:0]  pc_in,
    output logic [7:0]  pc_out,
    output logic [7:0]  pc_oe
);

    logic              rd_qual;
    logic              wr_commit;
    logic              rd_start;
    logic              mode_set;
    logic              bsr_set;
    cfg_t              cfg_q;
    logic [PORT_W-2:0] cfg_word;
    logic [PORT_W-1:0] lat_a;
    logic [PORT_W-1:0] lat_b;
    logic [PORT_W-1:0] lat_c;
    logic [PORT_W-1:0] cap_a;
    logic [PORT_W-1:0] pc_rd;
    logic [NIB_N-1:0]  nib_in;

    par_io_bus_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .cs_n      (cs_n),
        .rd_n      (rd_n),
        .wr_n      (wr_n),
        .rd_qual   (rd_qual),
        .wr_commit (wr_commit),
        .rd_start  (rd_start)
    );

    par_io_cfg u_cfg (
        .clk      (clk),
        .rst      (rst),
        .ctrl_wr  (wr_commit && (addr == SEL_CW)),
        .din      (din),
        .cfg_q    (cfg_q),
        .mode_set (mode_set),
        .bsr_set  (bsr_set)
    );

    par_io_latches u_lat (
        .clk       (clk),
        .rst       (rst),
        .wr_commit (wr_commit),
        .rd_start  (rd_start),
        .addr      (addr),
        .din       (din),
        .mode_set  (mode_set),
        .bsr_set   (bsr_set),
        .pa_in     (pa_in),
        .lat_a     (lat_a),
        .lat_b     (lat_b),
        .lat_c     (lat_c),
        .cap_a     (cap_a)
    );

    assign cfg_word = cfg_q;
    assign nib_in   = {cfg_q.cu_in, cfg_q.cl_in};

    assign pa_out = lat_a;
    assign pb_out = lat_b;
    assign pc_out = lat_c;
    assign pa_oe  = {PORT_W{~cfg_q.a_in}};
    assign pb_oe  = {PORT_W{~cfg_q.b_in}};

    for (genvar n = 0; n < NIB_N; n++) begin : g_pc_nib
        assign pc_oe[n*NIB_W +: NIB_W] = {NIB_W{~nib_in[n]}};
        assign pc_rd[n*NIB_W +: NIB_W] = nib_in[n] ? pc_in[n*NIB_W +: NIB_W]
                                                   : lat_c[n*NIB_W +: NIB_W];
    end

    assign doe = rd_qual;

    always_comb begin
        unique case (addr)
            SEL_PA:  dout = cfg_q.a_in ? cap_a : lat_a;
            SEL_PB:  dout = cfg_q.b_in ? pb_in : lat_b;
            SEL_PC:  dout = pc_rd;
            default: dout = {1'b1, cfg_word};
        endcase
    end

endmodule

// File: rtl/par_io_chk.sv
module par_io_chk (
    input logic       clk,
    input logic       rst,
    input logic       cs_n,
    input logic       rd_n,
    input logic       wr_n,
    input logic [1:0] addr,
    input logic [7:0] din,
    input logic [7:0] dout,
    input logic       doe,
    input logic [7:0] pa_out,
    input logic [7:0] pa_oe,
    input logic [7:0] pb_out,
    input logic [7:0] pb_oe,
    input logic [7:0] pc_out,
    input logic [7:0] pc_oe,
    input logic [6:0] cfg_word
);

    logic wr_now;
    logic wr_prev;
    logic ctl_start;

    assign wr_now    = !cs_n && !wr_n && rd_n;
    assign ctl_start = wr_now && !wr_prev && (addr == 2'd3);

    always_ff @(posedge clk) begin
        if (rst) wr_prev <= 1'b0;
        else     wr_prev <= wr_now;
    end

    // R3
    doe_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (cs_n || (rd_n == wr_n)) |-> !doe);

    // R7
    cfg_msb_chk: assert property (@(posedge clk) disable iff (rst)
        (doe && addr == 2'd3) |-> dout[7]);

    // R6
    mode_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl_start && din[7]) |=> (pa_out == 8'h00 && pb_out == 8'h00 && pc_out == 8'h00));

    // R8
    bsr_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl_start && !din[7]) |=> (cfg_word == $past(cfg_word)));

    // R5
    oe_group_chk: assert property (@(posedge clk) disable iff (rst)
        (pa_oe == 8'h00 || pa_oe == 8'hFF) && (pb_oe == 8'h00 || pb_oe == 8'hFF) &&
        (pc_oe[7:4] == 4'h0 || pc_oe[7:4] == 4'hF) && (pc_oe[3:0] == 4'h0 || pc_oe[3:0] == 4'hF));

    // R4
    rst_state_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (pa_oe == 8'h00 && pb_oe == 8'h00 && pc_oe == 8'h00 &&
                        pa_out == 8'hFF && cfg_word == 7'h1B));

endmodule

bind par_io_ctrl par_io_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .cs_n     (cs_n),
    .rd_n     (rd_n),
    .wr_n     (wr_n),
    .addr     (addr),
    .din      (din),
    .dout     (dout),
    .doe      (doe),
    .pa_out   (pa_out),
    .pa_oe    (pa_oe),
    .pb_out   (pb_out),
    .pb_oe    (pb_oe),
    .pc_out   (pc_out),
    .pc_oe    (pc_oe),
    .cfg_word (cfg_word)
);

// File: tb/test_par_io_ctrl.sv
`timescale 1ns/1ps
module test_par_io_ctrl;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic [1:0] addr = 2'd0;
    logic [7:0] din = 8'h00;
    logic [7:0] pa_in = 8'h00, pb_in = 8'h00, pc_in = 8'h00;
    logic [7:0] dout, pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;
    logic       doe;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    par_io_ctrl i_par_io_ctrl (
        .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .addr(addr), .din(din), .dout(dout), .doe(doe),
        .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
        .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
        .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe)
    );

    // reference model state
    logic [6:0] m_cfg;
    logic [7:0] m_la, m_lb, m_lc, m_cap;
    bit         m_inw, m_inr;

    always @(posedge clk) begin
        bit wq, rq;
        if (rst) begin
            m_cfg = 7'h1B; m_la = 8'hFF; m_lb = 8'hFF; m_lc = 8'hFF;
            m_cap = 8'h00; m_inw = 0; m_inr = 0;
        end else begin
            wq = !cs_n && !wr_n && rd_n;
            rq = !cs_n && !rd_n && wr_n;
            if (wq && !m_inw) begin
                case (addr)
                    2'd0: m_la = din;
                    2'd1: m_lb = din;
                    2'd2: m_lc = din;
                    default: begin
                        if (din[7]) begin
                            m_cfg = din[6:0]; m_la = 0; m_lb = 0; m_lc = 0;
                        end else begin
                            m_lc[din[3:1]] = din[0];
                        end
                    end
                endcase
            end
            if (rq && !m_inr) m_cap = pa_in;
            m_inw = wq;
            m_inr = rq;
        end
    end

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        logic [7:0] e;
        if (!rst && !done) begin
            chk("R3 doe", {7'b0, doe}, {7'b0, (!cs_n && !rd_n && wr_n)});
            chk("R4 R5 pa_oe", pa_oe, m_cfg[4] ? 8'h00 : 8'hFF);
            chk("R4 R5 pb_oe", pb_oe, m_cfg[1] ? 8'h00 : 8'hFF);
            chk("R4 R5 pc_oe", pc_oe, {m_cfg[3] ? 4'h0 : 4'hF, m_cfg[0] ? 4'h0 : 4'hF});
            chk("R2 R6 R12 pa_out", pa_out, m_la);
            chk("R2 R6 pb_out", pb_out, m_lb);
            chk("R6 R8 pc_out", pc_out, m_lc);
            if (!cs_n && !rd_n && wr_n) begin
                case (addr)
                    2'd0: begin
                        e = m_cfg[4] ? m_cap : m_la;
                        chk(m_cfg[4] ? "R1 R9 read A" : "R1 R11 read A", dout, e);
                    end
                    2'd1: begin
                        e = m_cfg[1] ? pb_in : m_lb;
                        chk(m_cfg[1] ? "R1 R10 read B" : "R1 R11 read B", dout, e);
                    end
                    2'd2: begin
                        e = {m_cfg[3] ? pc_in[7:4] : m_lc[7:4], m_cfg[0] ? pc_in[3:0] : m_lc[3:0]};
                        chk("R1 R10 R11 read C", dout, e);
                    end
                    default: chk("R1 R7 R12 read ctrl", dout, {1'b1, m_cfg});
                endcase
            end
        end
    end

    task automatic cyc(input int n);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        addr = a; din = d; cs_n = 0; wr_n = 0;
        cyc(2);
        wr_n = 1; cs_n = 1;
        cyc(1);
    endtask

    task automatic bus_read(input logic [1:0] a);
        addr = a; cs_n = 0; rd_n = 0;
        cyc(2);
        rd_n = 1; cs_n = 1;
        cyc(1);
    endtask

    initial begin
        cyc(4);
        rst = 0;
        cyc(3);
        // R4 reset readback
        bus_read(2'd3);
        // R10 R9 inputs
        pa_in = 8'h5A; pb_in = 8'hC3; pc_in = 8'h96;
        bus_read(2'd0); bus_read(2'd1); bus_read(2'd2);
        // R9 pins change during a held read
        addr = 2'd0; cs_n = 0; rd_n = 0;
        cyc(1); pa_in = 8'h3C; cyc(2);
        rd_n = 1; cs_n = 1; cyc(1);
        bus_read(2'd0);
        // R5 R6 all outputs
        bus_write(2'd3, 8'h80);
        bus_write(2'd0, 8'h11); bus_write(2'd1, 8'h22); bus_write(2'd2, 8'h33);
        bus_read(2'd0); bus_read(2'd1); bus_read(2'd2); bus_read(2'd3);
        // R2 unqualified strobes
        addr = 2'd0; din = 8'hEE; cs_n = 1; wr_n = 0; cyc(2); wr_n = 1; cyc(1);
        cs_n = 0; rd_n = 0; wr_n = 0; cyc(2); rd_n = 1; wr_n = 1; cs_n = 1; cyc(1);
        // R2 din changes during one long strobe
        addr = 2'd1; din = 8'h44; cs_n = 0; wr_n = 0; cyc(1);
        din = 8'h77; cyc(2); wr_n = 1; cs_n = 1; cyc(1);
        bus_read(2'd1);
        // R8 bit set/reset
        bus_write(2'd3, 8'h0F); bus_write(2'd3, 8'h06); bus_write(2'd3, 8'h01);
        bus_read(2'd3); bus_read(2'd2);
        // R5 split port C
        bus_write(2'd3, 8'h88);
        bus_write(2'd2, 8'hA5);
        pc_in = 8'h7E; bus_read(2'd2);
        pc_in = 8'hB1; bus_read(2'd2);
        // R12 non-zero mode codes, R6 clear over nonzero latches
        bus_write(2'd0, 8'h9D);
        bus_write(2'd3, 8'hE5);
        bus_read(2'd3);
        pb_in = 8'h81; bus_read(2'd1); bus_read(2'd0); bus_read(2'd2);
        bus_write(2'd3, 8'h0B);
        bus_read(2'd2);
        // back-to-back read then write without idle
        addr = 2'd2; cs_n = 0; rd_n = 0; cyc(1);
        rd_n = 1; wr_n = 0; din = 8'h5C; cyc(2);
        wr_n = 1; cs_n = 1; cyc(2);
        bus_read(2'd2);
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule